// File: doc/BRIEF.md
# Timer Input Clock Prescaler Tree

This block makes the per-cycle tick enables for five timer channels, all in one peripheral clock domain. Two 8-bit prescalers count peripheral clock cycles. Each channel takes the ticks of the prescaler assigned to it and thins them with its own power-of-two divider. A select bit in the channel's field can replace that divided tick with the rising edges of an external timer clock. The external clock is first synchronized into the peripheral clock domain.

Software sets the tree up through a small word-addressed register port. One register holds both prescaler values and one holds the five channel fields. Reads return the addressed register at once. A write takes effect at the clock edge that samples it, and it restarts the counters that the written register governs. The register port and the tick outputs are plain control signals. No data stream flows through the block, so there is no valid/ready handshake and no back-pressure to manage.

Top module: `tct_tick_tree`

## Requirements
- R1: After reset both configuration registers read zero, so every channel runs undivided and each `tick_o` bit is high on every cycle from the second cycle after reset release.
- R2: The prescaler register sits at offset 0x00. Prescaler A is in bits [7:0] and prescaler B is in bits [15:8]. A write there is read back exactly.
- R3: The channel register sits at offset 0x04. Channel c uses bits [4c+3:4c]: bits [4c+2:4c] are the divider code and bit 4c+3 is the external-clock select. A write there is read back exactly.
- R4: A prescaler value N yields one tick every N+1 peripheral cycles. Zero is legal and yields a tick on every cycle.
- R5: Prescaler A drives channels 0 and 1. Prescaler B drives channels 2, 3 and 4.
- R6: Divider codes 0, 1, 2, 3 and 4 divide by 1, 2, 4, 8 and 16. Codes 5, 6 and 7 also divide by 16.
- R7: A write to offset 0x00 restarts both prescalers and all channel dividers. A write to offset 0x04 restarts the channel dividers. Afterwards, with select clear, `tick_o[c]` is high exactly on cycles P, 2P, 3P, and so on after the write edge, where P = (N+1)·2^k.
- R8: With select set, a rising edge on `ext_clk[0]` (channels 0 and 1) or `ext_clk[1]` (channels 2 to 4) makes `tick_o[c]` high for exactly one cycle, on the third cycle after the edge that first samples the new level. The other group's input has no effect on the channel.
- R9: An external input that stays high, or that falls, makes no tick.
- R10: Unused register bits read zero: [31:16] at 0x00 and [31:20] at 0x04. Writes to any other offset change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ext_clk | input | 2 | External timer clocks, one per channel group, asynchronous |
| tick_o | output | 5 | Per-channel tick enable, registered |

## Verification
Read data comes back in the same cycle as the address, so the bench samples `rdata` 1 ns after setting `addr`. A divided tick is due P cycles after the restarting write edge, counting the output register. The bench always writes the prescaler register last, so that every counter restarts on one edge, and then compares each channel's output against the period formula on every one of the following 600 negative edges. An external edge travels through two synchronizer flops, the edge-detect flop and the output register. The bench drives the edge at a negative edge and expects the pulse on the third negative edge after that, with the outputs low on the second and fourth.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int NUM_CH   = 5;
  localparam int NUM_GRP  = 2;
  localparam int GRP0_CH  = 2;
  localparam int PRE_W    = 8;
  localparam int FLD_W    = 4;
  localparam int CODE_W   = 3;
  localparam int LOG_MAX  = 4;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam logic [ADDR_W-1:0] OFS_PRE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CH  = 8'h04;

  function automatic int grp_of(input int ch);
    return (ch < GRP0_CH) ? 0 : 1;
  endfunction
endpackage

// File: rtl/tct_regs.sv
module tct_regs
  import tct_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic [NUM_GRP*PRE_W-1:0]  pre_flat,
  output logic [NUM_CH*FLD_W-1:0]   ch_flat,
  output logic                      pre_restart,
  output logic                      ch_restart
);
  localparam int PRE_BITS = NUM_GRP * PRE_W;
  localparam int CH_BITS  = NUM_CH * FLD_W;

  logic pre_hit, ch_hit;
  logic [PRE_BITS-1:0] pre_q;
  logic [CH_BITS-1:0]  ch_q;

  assign pre_hit     = wr_en && (addr == OFS_PRE);
  assign ch_hit      = wr_en && (addr == OFS_CH);
  assign pre_restart = pre_hit;
  assign ch_restart  = pre_hit | ch_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      ch_q  <= '0;
    end else begin
      if (pre_hit) pre_q <= wdata[PRE_BITS-1:0];
      if (ch_hit)  ch_q  <= wdata[CH_BITS-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_PRE)     rdata = {{(DATA_W-PRE_BITS){1'b0}}, pre_q};
    else if (addr == OFS_CH) rdata = {{(DATA_W-CH_BITS){1'b0}}, ch_q};
  end

  assign pre_flat = pre_q;
  assign ch_flat  = ch_q;
endmodule

// File: rtl/tct_prescaler.sv
module tct_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/tct_chan_div.sv
module tct_chan_div #(
  parameter int LOG_MAX = 4,
  parameter int CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              pre_tick,
  input  logic [CODE_W-1:0] code,
  output logic              div_tick
);
  localparam int SH_W = $clog2(LOG_MAX + 1);

  logic [LOG_MAX-1:0] cnt;
  logic [LOG_MAX-1:0] mask;
  logic [SH_W-1:0]    shift;

  always_comb begin
    if (int'(code) >= LOG_MAX) shift = SH_W'(LOG_MAX);
    else                       shift = SH_W'(code);
    for (int i = 0; i < LOG_MAX; i++) mask[i] = (SH_W'(i) < shift);
  end

  assign div_tick = pre_tick && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (pre_tick) cnt <= cnt + LOG_MAX'(1);
  end
endmodule

// File: rtl/tct_ext_sync.sv
module tct_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic pulse
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ext_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign pulse = s2 & ~s3;
endmodule

// File: rtl/tct_tick_tree.sv
module tct_tick_tree
  import tct_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_GRP-1:0] ext_clk,
  output logic [NUM_CH-1:0]  tick_o
);
  logic [NUM_GRP*PRE_W-1:0] pre_flat;
  logic [NUM_CH*FLD_W-1:0]  ch_flat;
  logic                     pre_restart, ch_restart;
  logic                     cfg_wr;
  logic [NUM_GRP-1:0]       pre_tick, ext_tick;
  logic [NUM_CH-1:0]        div_tick, next_tick;
  logic [NUM_CH-1:0]        tick_q;

  tct_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pre_flat(pre_flat), .ch_flat(ch_flat),
    .pre_restart(pre_restart), .ch_restart(ch_restart)
  );

  assign cfg_wr = ch_restart;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    tct_prescaler #(.W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(pre_restart),
      .limit(pre_flat[g*PRE_W +: PRE_W]), .tick(pre_tick[g])
    );
    tct_ext_sync u_sync (
      .clk(clk), .rst_n(rst_n), .ext_in(ext_clk[g]), .pulse(ext_tick[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int G = grp_of(c);
    logic [FLD_W-1:0] fld;
    assign fld = ch_flat[c*FLD_W +: FLD_W];

    tct_chan_div #(.LOG_MAX(LOG_MAX), .CODE_W(CODE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .restart(ch_restart),
      .pre_tick(pre_tick[G]), .code(fld[CODE_W-1:0]), .div_tick(div_tick[c])
    );

    assign next_tick[c] = fld[FLD_W-1] ? ext_tick[G] : div_tick[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= next_tick;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/tct_tick_tree_chk.sv
module tct_tick_tree_chk
  import tct_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        addr,
  input logic [DATA_W-1:0]        wdata,
  input logic [DATA_W-1:0]        rdata,
  input logic [NUM_CH-1:0]        tick_o,
  input logic [NUM_GRP*PRE_W-1:0] pre_flat,
  input logic [NUM_CH*FLD_W-1:0]  ch_flat,
  input logic                     cfg_wr
);
  a_r10_unused_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_PRE) |-> (rdata[DATA_W-1:16] == '0));

  a_r10_unused_ch: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_CH) |-> (rdata[DATA_W-1:20] == '0));

  a_r10_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != OFS_PRE && addr != OFS_CH) |=> ($stable(pre_flat) && $stable(ch_flat)));

  a_r2_pre_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_PRE) |=> (pre_flat == $past(wdata[15:0])));

  a_r3_ch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CH) |=> (ch_flat == $past(wdata[19:0])));

  a_r4_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && pre_flat[7:0] == 8'd0 && ch_flat[3:0] == 4'd0) |=> tick_o[0]);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o[0] && ch_flat[3] && $past(ch_flat[3])) |=> !tick_o[0]);
endmodule

bind tct_tick_tree tct_tick_tree_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .tick_o(tick_o), .pre_flat(pre_flat), .ch_flat(ch_flat),
  .cfg_wr(cfg_wr)
);

// File: tb/tb_tct_tick_tree.sv
`timescale 1ns/1ps
module tb_tct_tick_tree;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  ext_clk = 2'b00;
  logic [4:0]  tick_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tct_tick_tree dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_clk(ext_clk), .tick_o(tick_o)
  );

  typedef struct packed {
    logic [7:0]       p0;
    logic [7:0]       p1;
    logic [19:0]      fld;
    logic [4:0][15:0] per;
  } vec_t;

  localparam int NV = 4;
  localparam int WIN = 600;
  localparam vec_t VECS [NV] = '{
    '{8'd0,   8'd0, 20'h00000, {16'd1,  16'd1,  16'd1,  16'd1,   16'd1}},
    '{8'd2,   8'd1, 20'h43021, {16'd32, 16'd16, 16'd2,  16'd12,  16'd6}},
    '{8'd4,   8'd0, 20'h21675, {16'd4,  16'd2,  16'd16, 16'd80,  16'd80}},
    '{8'd255, 8'd3, 20'h02410, {16'd4,  16'd16, 16'd64, 16'd512, 16'd256}}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] save0, save1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values and full-rate ticks
    reg_read(8'h00, rd); check("R1 reset pre reg", rd, 32'h0);
    reg_read(8'h04, rd); check("R1 reset ch reg", rd, 32'h0);
    @(negedge clk);
    @(negedge clk);
    begin
      int bad = 0;
      for (int k = 0; k < 8; k++) begin
        if (tick_o !== 5'h1F) bad++;
        @(negedge clk);
      end
      check("R1 R4 every-cycle ticks after reset", bad, 0);
    end

    // Vector table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      int first_bad [5];
      logic [4:0] first_act;
      reg_write(8'h04, {12'h0, VECS[v].fld});
      reg_write(8'h00, {16'h0, VECS[v].p1, VECS[v].p0});
      for (int ch = 0; ch < 5; ch++) first_bad[ch] = -1;
      first_act = '0;
      for (int c = 1; c <= WIN; c++) begin
        @(negedge clk);
        for (int ch = 0; ch < 5; ch++) begin
          logic e;
          e = ((c % int'(VECS[v].per[ch])) == 0);
          if (tick_o[ch] !== e && first_bad[ch] < 0) begin
            first_bad[ch] = c;
            first_act[ch] = tick_o[ch];
          end
        end
      end
      for (int ch = 0; ch < 5; ch++) begin
        n_chk++;
        if (first_bad[ch] >= 0) begin
          n_bad++;
          $display("FAIL R7 R5 R6 vec %0d ch %0d cycle %0d: actual %0b expected %0b",
                   v, ch, first_bad[ch], first_act[ch], ~first_act[ch]);
        end
      end
      reg_read(8'h00, rd); check("R2 pre readback", rd, {16'h0, VECS[v].p1, VECS[v].p0});
      reg_read(8'h04, rd); check("R3 ch readback", rd, {12'h0, VECS[v].fld});
    end

    // R10: unused bits read zero, unmapped write ignored
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_read(8'h00, rd); check("R10 pre unused bits", rd, 32'h0000_FFFF);
    reg_write(8'h04, 32'hFFFF_FFFF);
    reg_read(8'h04, rd); check("R10 ch unused bits", rd, 32'h000F_FFFF);
    reg_write(8'h00, 32'h0000_1234);
    reg_write(8'h04, 32'h0005_6789);
    reg_read(8'h00, save0);
    reg_read(8'h04, save1);
    reg_write(8'h08, 32'hFFFF_FFFF);
    reg_write(8'h05, 32'h0000_0000);
    reg_read(8'h00, rd); check("R10 unmapped write pre", rd, save0);
    reg_read(8'h04, rd); check("R10 unmapped write ch", rd, save1);

    // R8 R9: external clock path; ch0 and ch2 select external
    reg_write(8'h04, 32'h0004_4848);
    reg_write(8'h00, 32'h0000_FFFF);
    repeat (4) @(negedge clk);
    ext_clk = 2'b01;
    begin
      logic [3:0] seen0, seen2;
      for (int k = 1; k <= 4; k++) begin
        @(negedge clk);
        seen0[k-1] = tick_o[0];
        seen2[k-1] = tick_o[2];
      end
      check("R8 ext0 pulse timing ch0", {28'h0, seen0}, 32'h4);
      check("R8 ext0 ignored by ch2", {28'h0, seen2}, 32'h0);
    end
    begin
      int cnt = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        cnt += int'(tick_o[0]);
      end
      check("R9 held-high ext0 no tick", cnt, 0);
    end
    ext_clk = 2'b10;
    begin
      logic [3:0] seen0, seen2;
      for (int k = 1; k <= 4; k++) begin
        @(negedge clk);
        seen0[k-1] = tick_o[0];
        seen2[k-1] = tick_o[2];
      end
      check("R8 ext1 pulse timing ch2", {28'h0, seen2}, 32'h4);
      check("R9 falling ext0 no tick ch0", {28'h0, seen0}, 32'h0);
    end
    ext_clk = 2'b00;
    begin
      int cnt = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        cnt += int'(tick_o[2]);
      end
      check("R9 falling ext1 no tick ch2", cnt, 0);
    end

    finish_run();
  end
endmodule